// File: doc/BRIEF.md
# Position Decoder Control Register with Cross-Domain Enable and Soft Reset

This block holds the 32-bit control word of a position-decoder peripheral. Software writes it one word at a time on a bus clock and reads it back combinationally. The word carries the operating mode, the decoder configuration, the input-source and inversion selects for three inputs, a period-enable flag, a phase-swap flag, an auto-lock flag, a run-in-standby flag, the angular counter length and a missing-pulse limit. Every configuration field is locked while the peripheral is enabled. A write that would change a locked field is dropped without any error.

The run bit and the soft-reset request do not take effect at once. Each one crosses into a slower core clock domain over its own toggle handshake, which uses a two-flop synchronizer in each direction. While a transfer is in flight, a busy output stays high. The core-side run state is the `core_run` output. A soft reset clears every field and stops the core. While the reset is in progress the soft-reset bit reads back as 1 and all other writes are refused.

A three-state machine on the bus side controls the sequence. Its states are ST_IDLE, ST_EN_WAIT (an enable change is in flight) and ST_RST_WAIT (a soft reset is in flight). Its transitions are:
- ST_IDLE to ST_EN_WAIT on a write that changes the run bit.
- ST_IDLE to ST_RST_WAIT on a write with the reset bit set.
- ST_EN_WAIT to ST_IDLE when the enable acknowledge returns.
- ST_EN_WAIT to ST_RST_WAIT on a write with the reset bit set (preemption).
- ST_RST_WAIT to ST_IDLE when the reset acknowledge returns, which also clears the word.

Top module: `posdec_ctrl`

## Requirements
- R1: After hardware reset, `rd_data` is 0, `busy_en` and `busy_rst` are low, and `core_run` is low.
- R2: Field layout of the word:
  - bit 0: run
  - bit 1: soft reset
  - bits 3:2: mode
  - bits 6:4: config
  - bit 7: auto-lock
  - bit 8: swap
  - bit 9: period enable
  - bit 10: standby run
  - bits 13:11: pin source
  - bits 16:14: pin invert
  - bits 19:17: angular length
  - bits 23:20: missing-pulse limit

  Bits 23:2 are written only when the stored run bit is 0 and no transfer is busy. Otherwise they keep their value.
- R3: A write whose run bit differs from the stored one updates the readback of bit 0 at once and sets `busy_en` from the next cycle. `busy_en` stays high until `core_run` equals the new value. A write with the same run value does not raise `busy_en`.
- R4: A write with bit 1 set raises `busy_rst` from the next cycle, and bit 1 reads as 1 while it is high. When `busy_rst` falls, `rd_data` is 0 and `core_run` is 0.
- R5: While `busy_rst` is high, writes with bit 1 clear change no field and no run state.
- R6: While `busy_en` is high, writes without bit 1 are ignored, including the run bit.
- R7: Mode codes are 0 quadrature, 1 hall and 2 counter. Writing code 3 keeps the previous mode while the other fields of the same write are still taken.
- R8: Config codes are 0 X4, 1 secure X4, 2 X2, 3 secure X2 and 4 auto-correction. Writing 5, 6 or 7 keeps the previous config.
- R9: A reset write while `busy_en` is high is accepted. The next cycle shows `busy_rst` high and `busy_en` low, and the reset completes as in R4.
- R10: A write that sets bit 1 and changes the run bit together starts only the reset. `busy_en` stays low.
- R11: Bits 31:24 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain reset, active low |
| core_clk | input | 1 | Core clock, slower than the bus clock |
| core_rst_n | input | 1 | Core-domain reset, active low |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word, with bit 1 showing reset in progress |
| busy_en | output | 1 | Run-bit transfer to the core in flight |
| busy_rst | output | 1 | Soft reset in flight |
| core_run | output | 1 | Run state as seen in the core domain |

## Verification
The hardest case to reach is a soft reset that arrives while an enable transfer is still crossing the domains. In that case both handshake channels are in flight at once, and the late enable acknowledge must be ignored. The bench reaches it by issuing an enable write and a reset write on back-to-back bus cycles, well inside the synchronizer latency. It then checks that the busy flags swap at once and that the core ends stopped. A second hard case is a write made while a transfer is busy. The bench reaches it by writing immediately after the busy flag rises, before any acknowledge can return.

// File: rtl/posdec_pkg.sv
package posdec_pkg;

    localparam int REG_W  = 32;
    localparam int MODE_W = 2;
    localparam int CFG_W  = 3;
    localparam int PIN_N  = 3;
    localparam int ANG_W  = 3;
    localparam int MISS_W = 4;
    localparam int USED_W = MISS_W + ANG_W + 2 * PIN_N + 4 + CFG_W + MODE_W + 2;
    localparam int RSV_W  = REG_W - USED_W;

    localparam logic [MODE_W-1:0] MODE_QUAD = 2'd0;
    localparam logic [MODE_W-1:0] MODE_HALL = 2'd1;
    localparam logic [MODE_W-1:0] MODE_CNT  = 2'd2;

    localparam logic [CFG_W-1:0] CFG_X4     = 3'd0;
    localparam logic [CFG_W-1:0] CFG_X4_SEC = 3'd1;
    localparam logic [CFG_W-1:0] CFG_X2     = 3'd2;
    localparam logic [CFG_W-1:0] CFG_X2_SEC = 3'd3;
    localparam logic [CFG_W-1:0] CFG_AUTO   = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_EN_WAIT  = 2'd1,
        ST_RST_WAIT = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic [RSV_W-1:0]  rsv;
        logic [MISS_W-1:0] miss_lim;
        logic [ANG_W-1:0]  ang_len;
        logic [PIN_N-1:0]  pin_inv;
        logic [PIN_N-1:0]  pin_src;
        logic              stby_run;
        logic              per_en;
        logic              swap;
        logic              auto_lock;
        logic [CFG_W-1:0]  cfg;
        logic [MODE_W-1:0] mode;
        logic              srst;
        logic              run;
    } ctrl_t;

    function automatic logic mode_ok(input logic [MODE_W-1:0] m);
        return (m == MODE_QUAD) || (m == MODE_HALL) || (m == MODE_CNT);
    endfunction

    function automatic logic cfg_ok(input logic [CFG_W-1:0] c);
        return (c == CFG_X4) || (c == CFG_X4_SEC) || (c == CFG_X2) ||
               (c == CFG_X2_SEC) || (c == CFG_AUTO);
    endfunction

endpackage

// File: rtl/posdec_tsync.sv
module posdec_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic evt
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SH_W-2:0], tgl_in};
    end

    // One-cycle pulse when the synchronized toggle changes level
    assign evt = sh_q[SH_W-1] ^ sh_q[SH_W-2];

endmodule

// File: rtl/posdec_core_side.sv
module posdec_core_side #(
    parameter int STAGES = 2
) (
    input  logic core_clk,
    input  logic core_rst_n,
    input  logic en_req_tgl,
    input  logic rst_req_tgl,
    input  logic en_target,
    output logic core_run,
    output logic en_ack_tgl,
    output logic rst_ack_tgl
);
    logic en_evt;
    logic rst_evt;

    posdec_tsync #(.STAGES(STAGES)) u_en_sync (
        .clk(core_clk), .rst_n(core_rst_n), .tgl_in(en_req_tgl), .evt(en_evt)
    );

    posdec_tsync #(.STAGES(STAGES)) u_rst_sync (
        .clk(core_clk), .rst_n(core_rst_n), .tgl_in(rst_req_tgl), .evt(rst_evt)
    );

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            core_run    <= 1'b0;
            en_ack_tgl  <= 1'b0;
            rst_ack_tgl <= 1'b0;
        end else begin
            // Reset request wins over an enable seen in the same cycle
            if (rst_evt)     core_run <= 1'b0;
            else if (en_evt) core_run <= en_target;
            en_ack_tgl  <= en_ack_tgl ^ en_evt;
            rst_ack_tgl <= rst_ack_tgl ^ rst_evt;
        end
    end

    a_r4_core_stops: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        rst_evt |=> !core_run);

endmodule

// File: rtl/posdec_ctrl_fsm.sv
module posdec_ctrl_fsm
    import posdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_srst,
    input  logic run_change,
    input  logic en_ack_evt,
    input  logic rst_ack_evt,
    output logic busy_en,
    output logic busy_rst,
    output logic cfg_we,
    output logic run_we,
    output logic clr_all,
    output logic en_req_tgl,
    output logic rst_req_tgl
);
    hs_state_e state_q, state_d;
    logic      start_en;
    logic      start_rst;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && wr_srst)          state_d = ST_RST_WAIT;
                else if (wr_en && run_change)  state_d = ST_EN_WAIT;
            end
            ST_EN_WAIT: begin
                if (wr_en && wr_srst)          state_d = ST_RST_WAIT;
                else if (en_ack_evt)           state_d = ST_IDLE;
            end
            ST_RST_WAIT: begin
                if (rst_ack_evt)               state_d = ST_IDLE;
            end
            default:                           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy_en   = (state_q == ST_EN_WAIT);
        busy_rst  = (state_q == ST_RST_WAIT);
        cfg_we    = (state_q == ST_IDLE) && wr_en && !wr_srst;
        run_we    = cfg_we && run_change;
        start_en  = run_we;
        start_rst = wr_en && wr_srst && (state_q != ST_RST_WAIT);
        clr_all   = (state_q == ST_RST_WAIT) && rst_ack_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_req_tgl  <= 1'b0;
            rst_req_tgl <= 1'b0;
        end else begin
            if (start_en)  en_req_tgl  <= ~en_req_tgl;
            if (start_rst) rst_req_tgl <= ~rst_req_tgl;
        end
    end

    a_r5_reset_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
        busy_rst |-> (!cfg_we && !run_we));

    a_r9_reset_preempts: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_en && wr_en && wr_srst) |=> (busy_rst && !busy_en));

    a_r10_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_en && !busy_rst && wr_en && wr_srst) |=> !busy_en);

    a_r3_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_en, busy_rst}));

endmodule

// File: rtl/posdec_ctrl_regs.sv
module posdec_ctrl_regs
    import posdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] wr_data,
    input  logic             cfg_we,
    input  logic             run_we,
    input  logic             clr_all,
    output ctrl_t            ctrl_q
);
    ctrl_t wd;
    assign wd = ctrl_t'(wr_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (clr_all) begin
            ctrl_q <= '0;
        end else begin
            // Locked fields move only while the stored run bit is clear
            if (cfg_we && !ctrl_q.run) begin
                ctrl_q.miss_lim  <= wd.miss_lim;
                ctrl_q.ang_len   <= wd.ang_len;
                ctrl_q.pin_inv   <= wd.pin_inv;
                ctrl_q.pin_src   <= wd.pin_src;
                ctrl_q.stby_run  <= wd.stby_run;
                ctrl_q.per_en    <= wd.per_en;
                ctrl_q.swap      <= wd.swap;
                ctrl_q.auto_lock <= wd.auto_lock;
                if (cfg_ok(wd.cfg))   ctrl_q.cfg  <= wd.cfg;
                if (mode_ok(wd.mode)) ctrl_q.mode <= wd.mode;
            end
            if (run_we) ctrl_q.run <= wd.run;
        end
    end

    a_r2_locked_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.run && !clr_all) |=> $stable(ctrl_q[REG_W-1:2]));

    a_r7_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok(ctrl_q.mode));

    a_r8_cfg_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok(ctrl_q.cfg));

endmodule

// File: rtl/posdec_ctrl.sv
module posdec_ctrl
    import posdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_clk,
    input  logic             core_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             busy_en,
    output logic             busy_rst,
    output logic             core_run
);
    ctrl_t ctrl_q;
    ctrl_t rd_s;
    ctrl_t wd;
    logic  cfg_we, run_we, clr_all;
    logic  en_req_tgl, rst_req_tgl;
    logic  en_ack_tgl, rst_ack_tgl;
    logic  en_ack_evt, rst_ack_evt;
    logic  run_change;

    assign wd         = ctrl_t'(wr_data);
    assign run_change = (wd.run != ctrl_q.run);

    posdec_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_srst(wd.srst), .run_change(run_change),
        .en_ack_evt(en_ack_evt), .rst_ack_evt(rst_ack_evt),
        .busy_en(busy_en), .busy_rst(busy_rst),
        .cfg_we(cfg_we), .run_we(run_we), .clr_all(clr_all),
        .en_req_tgl(en_req_tgl), .rst_req_tgl(rst_req_tgl)
    );

    posdec_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .cfg_we(cfg_we), .run_we(run_we), .clr_all(clr_all),
        .ctrl_q(ctrl_q)
    );

    posdec_core_side #(.STAGES(SYNC_STAGES)) u_core (
        .core_clk(core_clk), .core_rst_n(core_rst_n),
        .en_req_tgl(en_req_tgl), .rst_req_tgl(rst_req_tgl),
        .en_target(ctrl_q.run), .core_run(core_run),
        .en_ack_tgl(en_ack_tgl), .rst_ack_tgl(rst_ack_tgl)
    );

    posdec_tsync #(.STAGES(SYNC_STAGES)) u_en_ack_sync (
        .clk(clk), .rst_n(rst_n), .tgl_in(en_ack_tgl), .evt(en_ack_evt)
    );

    posdec_tsync #(.STAGES(SYNC_STAGES)) u_rst_ack_sync (
        .clk(clk), .rst_n(rst_n), .tgl_in(rst_ack_tgl), .evt(rst_ack_evt)
    );

    always_comb begin
        rd_s      = ctrl_q;
        rd_s.srst = busy_rst;
    end
    assign rd_data = rd_s;

    // The run target must hold still while the core may still sample it
    a_r6_run_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_en |=> $stable(ctrl_q.run));

    a_r4_clear_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_rst) |-> (ctrl_q == '0));

endmodule

// File: tb/posdec_ctrl_bench.sv
module posdec_ctrl_bench;

    localparam int CLK_PERIOD  = 10;
    localparam int CORE_PERIOD = 26;
    localparam int NVEC        = 8;
    localparam int WAIT_MAX    = 400;

    // {write data, expected readback}, run and reset bits clear
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_0004, 32'h0000_0004},   // R7 mode hall
        {32'h0000_000C, 32'h0000_0004},   // R7 reserved mode 3 keeps hall
        {32'h0000_0048, 32'h0000_0048},   // R8 counter + auto-correction
        {32'h0000_0070, 32'h0000_0040},   // R8 reserved cfg 7 keeps auto
        {32'hFFFF_FFF0, 32'h00FF_FFC0},   // R11 upper byte reads zero
        {32'h00AB_CD5C, 32'h00AB_CD40},   // R2 fields taken, R7 R8 reserved kept
        {32'h0012_3424, 32'h0012_3424},   // R2 mixed pattern
        {32'h0000_0000, 32'h0000_0000}    // R2 clear
    };

    logic        clk = 1'b0;
    logic        core_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy_en, busy_rst, core_run;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2)  clk = ~clk;
    always #(CORE_PERIOD/2) core_clk = ~core_clk;

    posdec_ctrl u_posdec_ctrl (
        .clk(clk), .rst_n(rst_n), .core_clk(core_clk), .core_rst_n(core_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .busy_en(busy_en), .busy_rst(busy_rst), .core_run(core_run)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int k;
        k = 0;
        while ((busy_en || busy_rst) && k < WAIT_MAX) begin
            @(negedge clk);
            k++;
        end
        check({req, " busy clears"}, {31'd0, busy_en | busy_rst}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        core_rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_data", rd_data, 32'd0);
        check("R1 busy", {30'd0, busy_en, busy_rst}, 32'd0);
        check("R1 core_run", {31'd0, core_run}, 32'd0);

        // Table of configuration writes while disabled
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][63:32]);
            check($sformatf("R2/R7/R8/R11 vec %0d", i), rd_data, VEC[i][31:0]);
        end

        // R3 enable with config
        wr(32'h0000_0049);
        check("R3 busy_en rises", {31'd0, busy_en}, 32'd1);
        check("R3 readback", rd_data, 32'h0000_0049);
        wait_idle("R3");
        check("R3 core_run on", {31'd0, core_run}, 32'd1);

        // R2 locked while enabled, R3 same run value no busy
        wr(32'h00FF_FF05);
        check("R2 locked fields", rd_data, 32'h0000_0049);
        check("R3 same run no busy", {31'd0, busy_en}, 32'd0);

        // R6 disable then write during busy
        wr(32'h0000_0048);
        check("R3 busy on disable", {31'd0, busy_en}, 32'd1);
        wr(32'h0000_0005);
        check("R6 write ignored while busy", rd_data, 32'h0000_0048);
        wait_idle("R6");
        check("R6 core_run off", {31'd0, core_run}, 32'd0);
        check("R6 final readback", rd_data, 32'h0000_0048);

        // R4 / R5 soft reset from running
        wr(32'h0000_0049);
        wait_idle("R4 pre");
        wr(32'h0000_0002);
        check("R4 busy_rst", {30'd0, busy_en, busy_rst}, 32'd1);
        check("R4 srst reads one", rd_data, 32'h0000_004B);
        wr(32'h0000_004C);
        check("R5 write blocked", rd_data, 32'h0000_004B);
        wait_idle("R4");
        check("R4 cleared", rd_data, 32'd0);
        check("R4 core stopped", {31'd0, core_run}, 32'd0);

        // R9 reset preempts an enable in flight
        wr(32'h0000_0001);
        wr(32'h0000_0002);
        check("R9 busy swap", {30'd0, busy_en, busy_rst}, 32'd1);
        wait_idle("R9");
        check("R9 cleared", rd_data, 32'd0);
        repeat (20) @(negedge clk);
        check("R9 core stays off", {31'd0, core_run}, 32'd0);
        check("R9 no late busy", {30'd0, busy_en, busy_rst}, 32'd0);

        // R10 reset and run change in one write
        wr(32'h0000_0003);
        check("R10 only reset busy", {30'd0, busy_en, busy_rst}, 32'd1);
        wait_idle("R10");
        check("R10 cleared", rd_data, 32'd0);
        check("R10 core off", {31'd0, core_run}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule